// File: doc/BRIEF.md
# Descriptor Chain DMA Sequencer

This block is the control engine of one DMA channel. When a trigger arrives it reads a 16-word descriptor from memory, waits for an external descriptor checker to accept or reject it, and then issues payload read requests. Payload is read either as strided lines or as up to five fragments that never cross a 4 KiB page. After the payload it can write the descriptor's timestamp-high word back with the done flag set, and it raises a completion event, a data-error event, or both. It then follows the next-descriptor link until a descriptor marked as the end of the chain or of the frame.

The chain position lives across runs. A run that ends on a chain end or an error leaves the channel "finished", so the next run begins at the programmed start address. A run stopped early by single-descriptor mode resumes at the latched next address. A retrigger pulse forces the next descriptor fetch back to the start address.

Memory and payload ports use a plain request/acknowledge handshake. Only one transfer is in flight at a time, and the request and its qualifiers are held until acknowledged.

Top module: `desc_chain_seq`

## Requirements
- R1: Out of reset there is no memory or payload request, `busy` and `evtSet` are low, and the channel counts as finished, so the first run fetches from `startAddr`.
- R2: A trigger pulse is held until the sequencer is idle. It is then consumed and starts a run only if `chEnable` is high and `chPause` is low; otherwise it is discarded, and enabling the channel later starts nothing.
- R3: A descriptor fetch is 16 word reads at the descriptor address plus 4·i, for i = 0..15. The descriptor address is `startAddr` when the channel is finished or a retrigger is pending. Otherwise it is the next address {word6[15:0], word7}.
- R4: In line mode (word0 bit 18 clear), each payload request has address {word6[31:16], word8} plus k times the stride and length word3[17:0]. The stride is word3[31:18]·16 bytes. Requests continue while the remaining byte count, which starts at word2, is at least one line.
- R5: If bytes remain once no further piece can be issued, the descriptor raises the data-error event bit 12+CHAN. This covers a transfer size that is not a multiple of the line size.
- R6: In fragment mode (word0 bit 18 set), the fragment addresses are {word6[31:16],word8}, {word9[15:0],word11}, {word9[31:16],word12}, {word10[15:0],word13} and {word10[31:16],word14}, used in that order. Each fragment length is the smaller of the remaining count and the bytes left to the next 4096-byte boundary.
- R7: When word0 bit 9 is set, one write of word5 with bit 31 forced to 1 goes to descriptor address + 20 after the last payload request. Memory and payload requests are never active together.
- R8: The per-descriptor event is a one-cycle pulse on `evtSet`. Bit CHAN is set when word0 bit 8 is set. Bit 12+CHAN is set on a payload error response, after which no further payload request is made for that descriptor. No other bit is ever set.
- R9: A descriptor with word0 bit 19 or bit 21 set ends the chain. The next run restarts at `startAddr`.
- R10: A checker rejection or a fetch read error aborts the run with no payload, write-back or event, and marks the channel finished.
- R11: With `singleDesc` high, a run stops after one descriptor. If that descriptor did not end the chain, the next run fetches from its next address.
- R12: A retrigger pulse makes the next descriptor fetch use `startAddr` even when the chain is not finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Trigger pulse |
| retrig | input | 1 | Retrigger pulse, forces restart at start address |
| chEnable | input | 1 | Channel enable |
| chPause | input | 1 | Channel pause |
| singleDesc | input | 1 | Stop after one descriptor per run |
| startAddr | input | AW | Chain start address |
| memReq | output | 1 | Descriptor memory request |
| memWe | output | 1 | Request is a write (write-back) |
| memAddr | output | AW | Descriptor memory byte address |
| memWdata | output | 32 | Write-back data |
| memAck | input | 1 | Memory acknowledge |
| memErr | input | 1 | Memory error, valid with acknowledge |
| memRdata | input | 32 | Read data, valid with acknowledge |
| verdictValid | input | 1 | Checker verdict available |
| verdictErr | input | 1 | Checker rejected the descriptor |
| pldReq | output | 1 | Payload read request |
| pldAddr | output | AW | Payload byte address |
| pldLen | output | LEN_W | Payload byte count |
| pldAck | input | 1 | Payload acknowledge |
| pldErr | input | 1 | Payload error, valid with acknowledge |
| evtSet | output | 32 | Event set pulse (bit CHAN done, bit 12+CHAN data error) |
| busy | output | 1 | Run in progress |

## Verification
Completion and data error can land in the same event pulse. The bench provokes this with a descriptor that asks for the completion event and whose transfer size leaves a remainder after the last full line, and again with a payload error response on a descriptor that also asks for completion. It judges the result by requiring exactly one `evtSet` pulse that carries both bit CHAN and bit 12+CHAN, with no write-back in the residue case.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned DESC_WORDS = 16;
  localparam int unsigned IDX_W      = $clog2(DESC_WORDS);

  // descriptor word indices
  localparam int unsigned W_CTRL     = 0;
  localparam int unsigned W_SIZE     = 2;
  localparam int unsigned W_LINE     = 3;
  localparam int unsigned W_TS_HI    = 5;
  localparam int unsigned W_EXT      = 6;
  localparam int unsigned W_NEXT     = 7;

  // control word bit positions
  localparam int unsigned CB_IRQ     = 8;
  localparam int unsigned CB_UPD     = 9;
  localparam int unsigned CB_FRAG    = 18;
  localparam int unsigned CB_LAST    = 19;
  localparam int unsigned CB_LASTFRM = 21;
  localparam int unsigned DONE_BIT   = 31;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_PAY, S_WBACK, S_EVENT
  } seqState_t;

  typedef struct packed {
    logic loadStart;
    logic loadNext;
    logic clrIdx;
    logic capWord;
    logic payInit;
    logic payStep;
  } seqStrobe_t;

  typedef struct packed {
    logic idxLast;
    logic payMore;
    logic residue;
    logic updEn;
    logic irqEn;
    logic chainEnd;
  } seqFlags_t;
endpackage

// File: rtl/dcs_datapath.sv
module dcs_datapath
  import dcs_pkg::*;
#(
  parameter int unsigned AW         = 48,
  parameter int unsigned LEN_W      = 18,
  parameter int unsigned FRAG_MAX   = 5,
  parameter int unsigned PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [AW-1:0]     startAddr,
  input  logic [WORD_W-1:0] memRdata,
  output seqFlags_t         flags,
  output logic [AW-1:0]     fetchAddr,
  output logic [AW-1:0]     wbAddr,
  output logic [WORD_W-1:0] wbData,
  output logic [AW-1:0]     pieceAddr,
  output logic [LEN_W-1:0]  pieceLen
);
  localparam int unsigned PG_W   = $clog2(PAGE_BYTES);
  localparam int unsigned FIDX_W = $clog2(FRAG_MAX + 1);

  logic [WORD_W-1:0] words [DESC_WORDS];
  logic [IDX_W-1:0]  idx;
  logic [AW-1:0]     descAddr;
  logic [AW-1:0]     curAddr;
  logic [WORD_W-1:0] remain;
  logic [FIDX_W-1:0] fragIdx;

  logic [AW-1:0]     srcAddr [FRAG_MAX+1];
  logic              fragMode;
  logic [17:0]       lineSize;
  logic [17:0]       stride;
  logic [PG_W:0]     pageRoom;
  logic [WORD_W-1:0] fragLen;
  logic [FIDX_W-1:0] fragNext;

  // fragment source addresses: low word plus a 16-bit high half
  for (genvar k = 0; k < FRAG_MAX; k++) begin : g_src
    localparam int LO = (k == 0) ? 8 : 10 + k;
    localparam int HW = (k == 0) ? 6 : 9 + (k - 1) / 2;
    localparam int HB = (k == 0) ? 16 : ((k - 1) % 2) * 16;
    assign srcAddr[k] = AW'({words[HW][HB +: 16], words[LO]});
  end
  assign srcAddr[FRAG_MAX] = '0;

  assign fragMode = words[W_CTRL][CB_FRAG];
  assign lineSize = words[W_LINE][17:0];
  assign stride   = {words[W_LINE][31:18], 4'b0000};
  assign pageRoom = (PG_W+1)'(PAGE_BYTES) - {1'b0, curAddr[PG_W-1:0]};
  assign fragLen  = (remain < WORD_W'(pageRoom)) ? remain : WORD_W'(pageRoom);
  assign fragNext = fragIdx + FIDX_W'(1);

  assign fetchAddr = descAddr + AW'({idx, 2'b00});
  assign wbAddr    = descAddr + AW'(W_TS_HI * 4);
  assign wbData    = words[W_TS_HI] | (WORD_W'(1) << DONE_BIT);
  assign pieceAddr = curAddr;
  assign pieceLen  = fragMode ? LEN_W'(fragLen) : LEN_W'(lineSize);

  always_comb begin
    flags.idxLast  = (idx == IDX_W'(DESC_WORDS - 1));
    flags.payMore  = fragMode ? ((remain != '0) && (fragIdx < FIDX_W'(FRAG_MAX)))
                              : ((lineSize != '0) && (remain >= WORD_W'(lineSize)));
    flags.residue  = (remain != '0);
    flags.updEn    = words[W_CTRL][CB_UPD];
    flags.irqEn    = words[W_CTRL][CB_IRQ];
    flags.chainEnd = words[W_CTRL][CB_LAST] | words[W_CTRL][CB_LASTFRM];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DESC_WORDS; i++) words[i] <= '0;
      idx      <= '0;
      descAddr <= '0;
      curAddr  <= '0;
      remain   <= '0;
      fragIdx  <= '0;
    end else begin
      if (stb.loadStart) descAddr <= startAddr;
      else if (stb.loadNext) descAddr <= AW'({words[W_EXT][15:0], words[W_NEXT]});

      if (stb.clrIdx) idx <= '0;
      else if (stb.capWord) begin
        words[idx] <= memRdata;
        idx        <= idx + IDX_W'(1);
      end

      if (stb.payInit) begin
        remain  <= words[W_SIZE];
        curAddr <= srcAddr[0];
        fragIdx <= '0;
      end else if (stb.payStep) begin
        remain <= remain - WORD_W'(pieceLen);
        if (fragMode) begin
          fragIdx <= fragNext;
          curAddr <= srcAddr[fragNext];
        end else begin
          curAddr <= curAddr + AW'(stride);
        end
      end
    end
  end
endmodule

// File: rtl/dcs_ctrl.sv
module dcs_ctrl
  import dcs_pkg::*;
#(
  parameter int unsigned CHAN     = 0,
  parameter int unsigned EVT_W    = 32,
  parameter int unsigned ERR_BASE = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trig,
  input  logic             retrig,
  input  logic             chEnable,
  input  logic             chPause,
  input  logic             singleDesc,
  input  logic             memAck,
  input  logic             memErr,
  input  logic             pldAck,
  input  logic             pldErr,
  input  logic             verdictValid,
  input  logic             verdictErr,
  input  seqFlags_t        flags,
  output seqStrobe_t       stb,
  output logic             memReq,
  output logic             memWe,
  output logic             pldReq,
  output logic [EVT_W-1:0] evtSet,
  output logic             busy
);
  seqState_t        state, nextState;
  logic             trigPend, retrigPend, finished, errFlag;
  logic             takeTrig, finSet, errSet, errClr, evtFire;
  logic             useStart;
  logic [EVT_W-1:0] evtQ;

  assign useStart = finished | retrigPend;

  always_comb begin
    stb       = '0;
    nextState = state;
    memReq    = 1'b0;
    memWe     = 1'b0;
    pldReq    = 1'b0;
    takeTrig  = 1'b0;
    finSet    = 1'b0;
    errSet    = 1'b0;
    errClr    = 1'b0;
    evtFire   = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (trigPend) begin
          takeTrig = 1'b1;
          if (chEnable && !chPause) begin
            stb.clrIdx    = 1'b1;
            stb.loadStart = useStart;
            stb.loadNext  = !useStart;
            nextState     = S_FETCH;
          end
        end
      end
      S_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          if (memErr) begin
            finSet    = 1'b1;
            nextState = S_IDLE;
          end else begin
            stb.capWord = 1'b1;
            if (flags.idxLast) nextState = S_CHECK;
          end
        end
      end
      S_CHECK: begin
        if (verdictValid) begin
          if (verdictErr) begin
            finSet    = 1'b1;
            nextState = S_IDLE;
          end else begin
            stb.payInit = 1'b1;
            errClr      = 1'b1;
            nextState   = S_PAY;
          end
        end
      end
      S_PAY: begin
        if (flags.payMore && !errFlag) begin
          pldReq = 1'b1;
          if (pldAck) begin
            if (pldErr) errSet = 1'b1;
            else stb.payStep = 1'b1;
          end
        end else begin
          errSet    = flags.residue;
          nextState = flags.updEn ? S_WBACK : S_EVENT;
        end
      end
      S_WBACK: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) nextState = S_EVENT;
      end
      S_EVENT: begin
        evtFire = 1'b1;
        if (flags.chainEnd) begin
          finSet    = 1'b1;
          nextState = S_IDLE;
        end else if (singleDesc) begin
          nextState = S_IDLE;
        end else begin
          stb.clrIdx    = 1'b1;
          stb.loadStart = retrigPend;
          stb.loadNext  = !retrigPend;
          nextState     = S_FETCH;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      trigPend   <= 1'b0;
      retrigPend <= 1'b0;
      finished   <= 1'b1;
      errFlag    <= 1'b0;
      evtQ       <= '0;
    end else begin
      state <= nextState;

      if (trig) trigPend <= 1'b1;
      else if (takeTrig) trigPend <= 1'b0;

      if (retrig) retrigPend <= 1'b1;
      else if (stb.loadStart) retrigPend <= 1'b0;

      if (finSet) finished <= 1'b1;
      else if (stb.loadStart) finished <= 1'b0;

      if (errClr) errFlag <= 1'b0;
      else if (errSet) errFlag <= 1'b1;

      if (evtFire)
        evtQ <= (EVT_W'(flags.irqEn) << CHAN) | (EVT_W'(errFlag) << (ERR_BASE + CHAN));
      else
        evtQ <= '0;
    end
  end

  assign evtSet = evtQ;
  assign busy   = (state != S_IDLE);
endmodule

// File: rtl/desc_chain_seq.sv
module desc_chain_seq
  import dcs_pkg::*;
#(
  parameter int unsigned AW         = 48,
  parameter int unsigned LEN_W      = 18,
  parameter int unsigned CHAN       = 0,
  parameter int unsigned FRAG_MAX   = 5,
  parameter int unsigned PAGE_BYTES = 4096
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trig,
  input  logic             retrig,
  input  logic             chEnable,
  input  logic             chPause,
  input  logic             singleDesc,
  input  logic [AW-1:0]    startAddr,
  output logic             memReq,
  output logic             memWe,
  output logic [AW-1:0]    memAddr,
  output logic [31:0]      memWdata,
  input  logic             memAck,
  input  logic             memErr,
  input  logic [31:0]      memRdata,
  input  logic             verdictValid,
  input  logic             verdictErr,
  output logic             pldReq,
  output logic [AW-1:0]    pldAddr,
  output logic [LEN_W-1:0] pldLen,
  input  logic             pldAck,
  input  logic             pldErr,
  output logic [31:0]      evtSet,
  output logic             busy
);
  seqStrobe_t    stb;
  seqFlags_t     flags;
  logic [AW-1:0] fetchAddr, wbAddr;

  dcs_ctrl #(.CHAN(CHAN), .EVT_W(32), .ERR_BASE(12)) ctrlI (
    .clk(clk), .rstN(rstN), .trig(trig), .retrig(retrig),
    .chEnable(chEnable), .chPause(chPause), .singleDesc(singleDesc),
    .memAck(memAck), .memErr(memErr), .pldAck(pldAck), .pldErr(pldErr),
    .verdictValid(verdictValid), .verdictErr(verdictErr), .flags(flags),
    .stb(stb), .memReq(memReq), .memWe(memWe), .pldReq(pldReq),
    .evtSet(evtSet), .busy(busy)
  );

  dcs_datapath #(.AW(AW), .LEN_W(LEN_W), .FRAG_MAX(FRAG_MAX), .PAGE_BYTES(PAGE_BYTES)) dpI (
    .clk(clk), .rstN(rstN), .stb(stb), .startAddr(startAddr), .memRdata(memRdata),
    .flags(flags), .fetchAddr(fetchAddr), .wbAddr(wbAddr), .wbData(memWdata),
    .pieceAddr(pldAddr), .pieceLen(pldLen)
  );

  assign memAddr = memWe ? wbAddr : fetchAddr;
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
  parameter int unsigned AW    = 48,
  parameter int unsigned LEN_W = 18,
  parameter int unsigned CHAN  = 0
) (
  input logic             clk,
  input logic             rstN,
  input logic             chEnable,
  input logic             chPause,
  input logic             memReq,
  input logic             memWe,
  input logic [AW-1:0]    memAddr,
  input logic             memAck,
  input logic             pldReq,
  input logic [AW-1:0]    pldAddr,
  input logic [LEN_W-1:0] pldLen,
  input logic             pldAck,
  input logic [31:0]      evtSet,
  input logic             busy
);
  localparam logic [31:0] EVT_MASK = (32'd1 << CHAN) | (32'd1 << (12 + CHAN));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memReq && !pldReq));

  assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(chEnable) && !$past(chPause)));

  assert_mem_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  assert_pld_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pldReq && !pldAck) |=> (pldReq && $stable(pldAddr) && $stable(pldLen)));

  assert_piece_nonzero_R4: assert property (@(posedge clk) disable iff (!rstN)
    pldReq |-> (pldLen != '0));

  assert_ports_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && pldReq));

  assert_evt_bits_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evtSet & ~EVT_MASK) == 32'd0);
endmodule

bind desc_chain_seq dcs_checker #(.AW(AW), .LEN_W(LEN_W), .CHAN(CHAN)) chkI (
  .clk(clk), .rstN(rstN), .chEnable(chEnable), .chPause(chPause),
  .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memAck(memAck),
  .pldReq(pldReq), .pldAddr(pldAddr), .pldLen(pldLen), .pldAck(pldAck),
  .evtSet(evtSet), .busy(busy)
);

// File: tb/desc_chain_seq_test.sv
`timescale 1ns/1ps
module desc_chain_seq_test;
  localparam int AW = 48;
  localparam int LEN_W = 18;
  localparam int CH = 2;
  localparam logic [31:0] B_IRQ = 32'h1 << 8;
  localparam logic [31:0] B_UPD = 32'h1 << 9;
  localparam logic [31:0] B_FRAG = 32'h1 << 18;
  localparam logic [31:0] B_LAST = 32'h1 << 19;
  localparam logic [31:0] B_LFRM = 32'h1 << 21;
  localparam logic [31:0] E_DONE = 32'h1 << CH;
  localparam logic [31:0] E_ERR = 32'h1 << (12 + CH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trig = 0, retrig = 0, chEnable = 0, chPause = 0, singleDesc = 0;
  logic [AW-1:0] startAddr = 48'h100;
  logic memReq, memWe, memAck = 0, memErr = 0;
  logic [AW-1:0] memAddr;
  logic [31:0] memWdata, memRdata = 0;
  logic verdictValid = 1, verdictErr = 0;
  logic pldReq, pldAck = 0, pldErr = 0;
  logic [AW-1:0] pldAddr;
  logic [LEN_W-1:0] pldLen;
  logic [31:0] evtSet;
  logic busy;

  always #2.5 clk = ~clk;

  desc_chain_seq #(.AW(AW), .LEN_W(LEN_W), .CHAN(CH)) uut (
    .clk(clk), .rstN(rstN), .trig(trig), .retrig(retrig), .chEnable(chEnable),
    .chPause(chPause), .singleDesc(singleDesc), .startAddr(startAddr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memErr(memErr), .memRdata(memRdata),
    .verdictValid(verdictValid), .verdictErr(verdictErr),
    .pldReq(pldReq), .pldAddr(pldAddr), .pldLen(pldLen), .pldAck(pldAck),
    .pldErr(pldErr), .evtSet(evtSet), .busy(busy)
  );

  int nChecks = 0, nFail = 0, cycles = 0;
  logic [31:0] mem [0:4095];
  int rdCnt, wrCnt, pldCnt, evtPulses;
  int memErrAt = -1, pldErrAt = -1;
  logic [31:0] evtAcc;
  logic [AW-1:0] rdAddr [0:63];
  logic [AW-1:0] wrAddr [0:63];
  logic [31:0] wrData [0:63];
  logic [AW-1:0] pAddr [0:63];
  logic [LEN_W-1:0] pLen [0:63];

  // memory, payload and event model
  initial begin
    forever begin
      @(negedge clk);
      memAck = 0; memErr = 0; pldAck = 0; pldErr = 0;
      if (rstN && memReq) begin
        memAck = 1;
        if (memWe) begin
          mem[memAddr[13:2]] = memWdata;
          if (wrCnt < 64) begin wrAddr[wrCnt] = memAddr; wrData[wrCnt] = memWdata; end
          wrCnt++;
        end else begin
          memRdata = mem[memAddr[13:2]];
          memErr = (rdCnt == memErrAt);
          if (rdCnt < 64) rdAddr[rdCnt] = memAddr;
          rdCnt++;
        end
      end
      if (rstN && pldReq) begin
        pldAck = 1;
        pldErr = (pldCnt == pldErrAt);
        if (pldCnt < 64) begin pAddr[pldCnt] = pldAddr; pLen[pldCnt] = pldLen; end
        pldCnt++;
      end
      if (evtSet != 0) begin evtAcc |= evtSet; evtPulses++; end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nFail++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
        $finish;
      end
    end
  end

  task automatic checkEq(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clearLogs();
    rdCnt = 0; wrCnt = 0; pldCnt = 0; evtPulses = 0; evtAcc = 0;
  endtask

  task automatic clearMem();
    for (int i = 0; i < 4096; i++) mem[i] = 0;
  endtask

  task automatic putDesc(input int base, input logic [31:0] w0, w2, w3, w5, w6, w7, w8,
                         input logic [31:0] w9, w11, w12);
    int b = base >> 2;
    for (int i = 0; i < 16; i++) mem[b + i] = 32'h0;
    mem[b] = w0; mem[b+2] = w2; mem[b+3] = w3; mem[b+5] = w5; mem[b+6] = w6;
    mem[b+7] = w7; mem[b+8] = w8; mem[b+9] = w9; mem[b+11] = w11; mem[b+12] = w12;
  endtask

  task automatic pulse(input bit isRetrig);
    @(negedge clk);
    if (isRetrig) retrig = 1; else trig = 1;
    @(negedge clk);
    retrig = 0; trig = 0;
  endtask

  task automatic runOnce();
    int t = 0;
    clearLogs();
    pulse(0);
    repeat (3) @(negedge clk);
    while (busy && t < 5000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    checkEq("R1 memReq in reset", memReq, 0);
    checkEq("R1 pldReq in reset", pldReq, 0);
    checkEq("R1 busy in reset", busy, 0);
    checkEq("R1 evtSet in reset", evtSet, 0);
    @(negedge clk); rstN = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic testGate();
    clearMem();
    putDesc(32'h100, B_LAST | B_IRQ, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    chEnable = 0; chPause = 0;
    runOnce();
    checkEq("R2 disabled trigger reads", rdCnt, 0);
    chEnable = 1;
    repeat (10) @(negedge clk);
    checkEq("R2 enable after dropped trigger", rdCnt + busy, 0);
    chPause = 1;
    runOnce();
    checkEq("R2 paused trigger reads", rdCnt, 0);
    chPause = 0;
  endtask

  task automatic testLines();
    clearMem();
    putDesc(32'h100, B_LAST | B_UPD | B_IRQ, 300, (32'd10 << 18) | 32'd100, 32'h1234,
            32'h0001_0000, 0, 32'h4000, 0, 0, 0);
    runOnce();
    checkEq("R3 fetch count", rdCnt, 16);
    checkEq("R1 first fetch uses start", rdAddr[0], 48'h100);
    checkEq("R3 last fetch word", rdAddr[15], 48'h13C);
    checkEq("R4 line count", pldCnt, 3);
    checkEq("R4 line0 addr", pAddr[0], 48'h1_0000_4000);
    checkEq("R4 line1 addr", pAddr[1], 48'h1_0000_40A0);
    checkEq("R4 line2 addr", pAddr[2], 48'h1_0000_4140);
    checkEq("R4 line len", pLen[2], 100);
    checkEq("R7 writeback count", wrCnt, 1);
    checkEq("R7 writeback addr", wrAddr[0], 48'h114);
    checkEq("R7 writeback data", wrData[0], 32'h8000_1234);
    checkEq("R8 done event", evtAcc, E_DONE);
    checkEq("R8 event pulses", evtPulses, 1);
  endtask

  task automatic testResidue();
    clearMem();
    putDesc(32'h100, B_LAST | B_IRQ, 250, (32'd10 << 18) | 32'd100, 0,
            0, 0, 32'h4000, 0, 0, 0);
    runOnce();
    checkEq("R5 full lines only", pldCnt, 2);
    checkEq("R5 done and error same pulse", evtAcc, E_DONE | E_ERR);
    checkEq("R5 single pulse", evtPulses, 1);
    checkEq("R7 no writeback without update", wrCnt, 0);
  endtask

  task automatic testFrag();
    clearMem();
    putDesc(32'h100, B_LAST | B_FRAG, 4452, 0, 0, 0, 0, 32'h0F00,
            32'h0003_0000, 32'h2000, 32'h5010);
    runOnce();
    checkEq("R6 fragment count", pldCnt, 3);
    checkEq("R6 frag0 addr", pAddr[0], 48'h0F00);
    checkEq("R6 frag0 len to page end", pLen[0], 256);
    checkEq("R6 frag1 addr", pAddr[1], 48'h2000);
    checkEq("R6 frag1 len full page", pLen[1], 4096);
    checkEq("R6 frag2 addr", pAddr[2], 48'h3_0000_5010);
    checkEq("R6 frag2 len remainder", pLen[2], 100);
    checkEq("R6 no event", evtAcc, 0);
  endtask

  task automatic putChain();
    clearMem();
    putDesc(32'h100, B_IRQ, 0, 0, 0, 0, 32'h200, 0, 0, 0, 0);
    putDesc(32'h200, B_LFRM | B_IRQ, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic testChain();
    putChain();
    runOnce();
    checkEq("R3 two descriptors fetched", rdCnt, 32);
    checkEq("R3 second uses next link", rdAddr[16], 48'h200);
    checkEq("R9 two done pulses", evtPulses, 2);
    runOnce();
    checkEq("R9 restart at start", rdAddr[0], 48'h100);
  endtask

  task automatic testSingle();
    putChain();
    singleDesc = 1;
    runOnce();
    checkEq("R11 one descriptor", rdCnt, 16);
    checkEq("R11 busy low after stop", busy, 0);
    runOnce();
    checkEq("R11 resumes at next", rdAddr[0], 48'h200);
    runOnce();
    checkEq("R9 after frame end restart", rdAddr[0], 48'h100);
  endtask

  task automatic testRetrig();
    pulse(1);
    runOnce();
    checkEq("R12 retrigger forces start", rdAddr[0], 48'h100);
  endtask

  task automatic testAbort();
    verdictErr = 1;
    runOnce();
    checkEq("R10 rejected fetch from next", rdAddr[0], 48'h200);
    checkEq("R10 no payload", pldCnt, 0);
    checkEq("R10 no writeback", wrCnt, 0);
    checkEq("R10 no event", evtPulses, 0);
    verdictErr = 0;
    runOnce();
    checkEq("R10 restart after reject", rdAddr[0], 48'h100);
    memErrAt = 3;
    runOnce();
    checkEq("R10 read error stops fetch", rdCnt, 4);
    checkEq("R10 read error no event", evtPulses, 0);
    memErrAt = -1;
    runOnce();
    checkEq("R10 restart after read error", rdAddr[0], 48'h100);
    singleDesc = 0;
  endtask

  task automatic testPayErr();
    clearMem();
    putDesc(32'h300, B_LAST | B_IRQ, 300, (32'd10 << 18) | 32'd100, 0,
            0, 0, 32'h4000, 0, 0, 0);
    startAddr = 48'h300;
    pulse(1);
    pldErrAt = 0;
    runOnce();
    pldErrAt = -1;
    checkEq("R8 payload stops on error", pldCnt, 1);
    checkEq("R8 error and done bits", evtAcc, E_DONE | E_ERR);
    checkEq("R12 retrigger picks new start", rdAddr[0], 48'h300);
  endtask

  initial begin
    clearLogs();
    testReset();
    chEnable = 1;
    testGate();
    testLines();
    testResidue();
    testFrag();
    testChain();
    testSingle();
    testRetrig();
    testAbort();
    testPayErr();
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end
endmodule